// File: doc/BRIEF.md
# Longest Prefix Match Routing Table

This block is a small associative table for IPv4 route lookup. Each slot holds a 32-bit address together with a 32-bit prefix mask and a valid bit. A lookup key is compared against every valid slot at once. Among the slots that agree with the key on all of their significant bits, the block reports the slot whose prefix is longest. The returned index is meant to address a next-hop memory that lives outside this block.

The longest prefix is found by a chain of mask bit-slices that runs from the least significant bit upward, instead of a fixed priority order over slot positions. Routes can therefore be stored in any slot, and adding or removing a route never moves another one. An internal last-in first-out list of free slots chooses where an insert lands and takes back the slot freed by a delete. Both operations complete in a single cycle.

Top module: `prefixMatchTable`

## Requirements
- R1: After reset no slot is valid, all slots are free, and `lookupHit`, `lookupIndex`, `opDone`, `opError` and `opSlot` are all 0.
- R2: A slot matches a key when it is valid and the key equals its stored address on every bit where that slot's mask bit is 1. Mask bit 1 means significant.
- R3: When one or more slots match, `lookupHit` is 1 and `lookupIndex` names the matching slot with the most mask ones. Among matching slots with equal masks, the lowest index wins. The result does not depend on the order of insertion.
- R4: When no slot matches, `lookupHit` is 0 and `lookupIndex` is 0.
- R5: The lookup result for the key present at a rising clock edge appears on the outputs after that edge. It reflects the table as it stood before any write taken at the same edge.
- R6: An insert (`opValid`=1, `opDelete`=0) on a table with a free slot takes the slot on top of the free list and stores the address, the mask and valid=1 there. After reset the free list hands out slots 0, 1, 2, … in ascending order. One cycle after any request, `opDone` pulses. For a successful request, `opSlot` gives the slot that was written or freed and `opError` is 0.
- R7: A delete (`opValid`=1, `opDelete`=1) of a valid slot `opIndex` clears its valid bit and pushes the index onto the free list. The next insert reuses the most recently freed slot.
- R8: An insert while no slot is free sets `opError`=1 and `opSlot`=0 and changes no slot and no free-list state.
- R9: A delete that names a slot that is not valid, including any delete on an empty table, sets `opError`=1 and `opSlot`=0 and changes no state.
- R10: A slot with an all-zero mask (prefix length 0) matches every key. It wins only when no other slot matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Table update request for this cycle |
| opDelete | input | 1 | 1 = delete slot `opIndex`, 0 = insert |
| opIndex | input | IDX_W | Slot to delete |
| opAddr | input | KEY_W | Address of the route to insert |
| opMask | input | KEY_W | Prefix mask of the route to insert, ones from the MSB |
| lookupKey | input | KEY_W | Key to look up, sampled every cycle |
| opDone | output | 1 | Pulses one cycle after an update request |
| opError | output | 1 | Request was rejected (table full or slot not valid) |
| opSlot | output | IDX_W | Slot written or freed, 0 on error |
| lookupHit | output | 1 | At least one slot matched the key |
| lookupIndex | output | IDX_W | Slot with the longest matching prefix, 0 on a miss |

## Verification
The assertions assume that every inserted mask is a run of ones starting at the MSB with only zeros below it. Under that assumption, the longest prefix is the same thing as the greatest number of mask ones. The stimulus only builds masks from a prefix length between 0 and 32, and a top-level assertion flags any insert that breaks this rule. The bench keeps its own model of the slots and of the free list. Its random keys are built by perturbing stored addresses, so that nested and equal-length prefixes compete often.

// File: rtl/prefixMatchPkg.sv
package prefixMatchPkg;

  // Strobes handed from the control to the table datapath.
  typedef struct packed {
    logic wrEn;   // store a new route in the selected slot
    logic clrEn;  // clear the valid bit of the selected slot
  } tblStrobe_t;

endpackage

// File: rtl/pmControl.sv
module pmControl
  import prefixMatchPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic               opDelete,
  input  logic [IDX_W-1:0]   opIndex,
  input  logic [ENTRIES-1:0] validVec,
  output tblStrobe_t         strobe,
  output logic [IDX_W-1:0]   slotSel,
  output logic               opDone,
  output logic               opError,
  output logic [IDX_W-1:0]   opSlot
);

  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);

  logic [IDX_W-1:0] freeList [ENTRIES];
  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] topPtr;
  logic [IDX_W-1:0] topIdx;
  logic isIns, isDel, insOk, delOk;

  assign isIns  = opValid && !opDelete;
  assign isDel  = opValid && opDelete;
  assign insOk  = isIns && (freeCnt != '0);
  assign delOk  = isDel && validVec[opIndex] && (freeCnt != FULL_CNT);
  assign topPtr = freeCnt - 1'b1;
  assign topIdx = (freeCnt == '0) ? '0 : freeList[topPtr[IDX_W-1:0]];

  always_comb begin
    strobe.wrEn  = insOk;
    strobe.clrEn = delOk;
    slotSel      = insOk ? topIdx : opIndex;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < ENTRIES; k++) freeList[k] <= IDX_W'(ENTRIES - 1 - k);
      freeCnt <= FULL_CNT;
      opDone  <= 1'b0;
      opError <= 1'b0;
      opSlot  <= '0;
    end else begin
      opDone  <= opValid;
      opError <= opValid && !(insOk || delOk);
      if (insOk) begin
        freeCnt <= freeCnt - 1'b1;
        opSlot  <= topIdx;
      end else if (delOk) begin
        freeList[freeCnt[IDX_W-1:0]] <= opIndex;
        freeCnt <= freeCnt + 1'b1;
        opSlot  <= opIndex;
      end else begin
        opSlot  <= '0;
      end
    end
  end

  // Every slot is either valid or on the free list, never both (R6, R7).
  assert_entry_balance_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(validVec) + int'(freeCnt)) == ENTRIES);

  assert_insert_pops_R6: assert property (@(posedge clk) disable iff (!rstN)
    insOk |=> opDone && !opError && (freeCnt == $past(freeCnt) - 1'b1));

  assert_delete_pushes_R7: assert property (@(posedge clk) disable iff (!rstN)
    delOk |=> opDone && !opError && (freeCnt == $past(freeCnt) + 1'b1));

  assert_full_reject_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isIns && freeCnt == '0) |=> opError && (freeCnt == '0) && (opSlot == '0));

  assert_bad_delete_R9: assert property (@(posedge clk) disable iff (!rstN)
    (isDel && !validVec[opIndex]) |=> opError && $stable(freeCnt) && (opSlot == '0));

endmodule

// File: rtl/pmPrefixFinder.sv
module pmPrefixFinder #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [KEY_W-1:0]   maskArr [ENTRIES],
  output logic               winHit,
  output logic [IDX_W-1:0]   winIdx
);

  logic [ENTRIES-1:0] sliceBits [KEY_W];
  logic [ENTRIES-1:0] winners;

  // Regroup the masks so that each bit position forms one slice across all slots.
  always_comb begin
    for (int j = 0; j < KEY_W; j++)
      for (int i = 0; i < ENTRIES; i++)
        sliceBits[j][i] = maskArr[i][j];
  end

  // Walk the slices from LSB to MSB. A slice that still holds a one among the
  // candidates drops every candidate with a zero in that position.
  always_comb begin
    logic [ENTRIES-1:0] cand;
    logic [ENTRIES-1:0] keep;
    cand = matchVec;
    for (int j = 0; j < KEY_W; j++) begin
      keep = cand & sliceBits[j];
      if (|keep) cand = keep;
    end
    winners = cand;
  end

  // Equal masks tie: the lowest slot index wins.
  always_comb begin
    winIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (winners[i]) winIdx = IDX_W'(i);
  end

  assign winHit = |winners;

endmodule

// File: rtl/pmDatapath.sv
module pmDatapath
  import prefixMatchPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tblStrobe_t         strobe,
  input  logic [IDX_W-1:0]   slotSel,
  input  logic [KEY_W-1:0]   opAddr,
  input  logic [KEY_W-1:0]   opMask,
  input  logic [KEY_W-1:0]   lookupKey,
  output logic [ENTRIES-1:0] validVec,
  output logic               lookupHit,
  output logic [IDX_W-1:0]   lookupIndex
);

  logic [KEY_W-1:0]   entAddr [ENTRIES];
  logic [KEY_W-1:0]   entMask [ENTRIES];
  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] matchVec;
  logic               winHit;
  logic [IDX_W-1:0]   winIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entAddr[i] <= '0;
        entMask[i] <= '0;
      end
    end else if (strobe.wrEn) begin
      entAddr[slotSel]  <= opAddr & opMask;
      entMask[slotSel]  <= opMask;
      entValid[slotSel] <= 1'b1;
    end else if (strobe.clrEn) begin
      entValid[slotSel] <= 1'b0;
    end
  end

  // Per-slot match flag under that slot's own mask.
  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    assign matchVec[i] = entValid[i] && (((lookupKey ^ entAddr[i]) & entMask[i]) == '0);
  end

  pmPrefixFinder #(
    .ENTRIES(ENTRIES),
    .KEY_W  (KEY_W),
    .IDX_W  (IDX_W)
  ) uFinder (
    .matchVec(matchVec),
    .maskArr (entMask),
    .winHit  (winHit),
    .winIdx  (winIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookupHit   <= 1'b0;
      lookupIndex <= '0;
    end else begin
      lookupHit   <= winHit;
      lookupIndex <= winIdx;
    end
  end

  assign validVec = entValid;

  assert_miss_index_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> (lookupIndex == '0));

  assert_no_match_no_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (matchVec == '0) |=> !lookupHit);

  assert_match_gives_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (matchVec != '0) |=> lookupHit);

  assert_write_sets_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> entValid[$past(slotSel)]);

  assert_clear_drops_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEn |=> !entValid[$past(slotSel)]);

endmodule

// File: rtl/prefixMatchTable.sv
module prefixMatchTable
  import prefixMatchPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic             opDelete,
  input  logic [IDX_W-1:0] opIndex,
  input  logic [KEY_W-1:0] opAddr,
  input  logic [KEY_W-1:0] opMask,
  input  logic [KEY_W-1:0] lookupKey,
  output logic             opDone,
  output logic             opError,
  output logic [IDX_W-1:0] opSlot,
  output logic             lookupHit,
  output logic [IDX_W-1:0] lookupIndex
);

  tblStrobe_t         strobe;
  logic [IDX_W-1:0]   slotSel;
  logic [ENTRIES-1:0] validVec;
  logic [KEY_W-1:0]   invMask;

  pmControl #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opDelete(opDelete),
    .opIndex (opIndex),
    .validVec(validVec),
    .strobe  (strobe),
    .slotSel (slotSel),
    .opDone  (opDone),
    .opError (opError),
    .opSlot  (opSlot)
  );

  pmDatapath #(
    .ENTRIES(ENTRIES),
    .KEY_W  (KEY_W),
    .IDX_W  (IDX_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .slotSel    (slotSel),
    .opAddr     (opAddr),
    .opMask     (opMask),
    .lookupKey  (lookupKey),
    .validVec   (validVec),
    .lookupHit  (lookupHit),
    .lookupIndex(lookupIndex)
  );

  // Input premise for R3: inserted masks are ones from the MSB, zeros below.
  assign invMask = ~opMask;
  assert_mask_contiguous_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opDelete) |-> ((invMask & (invMask + 1'b1)) == '0));

  assert_done_follows_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> opDone);

endmodule

// File: tb/tb_prefixMatchTable.sv
module tb_prefixMatchTable;

  localparam int ENTRIES = 16;
  localparam int KEY_W   = 32;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             opValid = 1'b0;
  logic             opDelete = 1'b0;
  logic [IDX_W-1:0] opIndex = '0;
  logic [KEY_W-1:0] opAddr = '0;
  logic [KEY_W-1:0] opMask = '0;
  logic [KEY_W-1:0] lookupKey = '0;
  logic             opDone, opError, lookupHit;
  logic [IDX_W-1:0] opSlot, lookupIndex;

  int checks = 0;
  int errors = 0;

  // Bench model of the table and of the free list.
  logic [KEY_W-1:0] refAddr [ENTRIES];
  logic [KEY_W-1:0] refMask [ENTRIES];
  logic             refValid [ENTRIES];
  int               mStack [ENTRIES];
  int               mCnt;

  // Lookup vectors after the directed table set-up: {key, hit, index}.
  localparam logic [36:0] VECS [6] = '{
    {32'h0A010203, 1'b1, 4'd2},   // /24 beats /16 and /8
    {32'h0A01FF00, 1'b1, 4'd1},   // two equal /16, lowest slot wins
    {32'h0A7F0000, 1'b1, 4'd0},   // only the /8 and the default fit
    {32'hC0A81234, 1'b1, 4'd4},   // separate /16
    {32'h08080808, 1'b1, 4'd3},   // default route only
    {32'hC0A90001, 1'b1, 4'd3}    // one bit off the /16, default wins
  };

  prefixMatchTable #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opDelete(opDelete),
    .opIndex(opIndex), .opAddr(opAddr), .opMask(opMask), .lookupKey(lookupKey),
    .opDone(opDone), .opError(opError), .opSlot(opSlot),
    .lookupHit(lookupHit), .lookupIndex(lookupIndex)
  );

  always #4 clk = ~clk;

  function automatic logic [KEY_W-1:0] lenMask(int len);
    if (len <= 0) return '0;
    return {KEY_W{1'b1}} << (KEY_W - len);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < ENTRIES; k++) begin
      refValid[k] = 1'b0; refAddr[k] = '0; refMask[k] = '0;
      mStack[k] = ENTRIES - 1 - k;
    end
    mCnt = ENTRIES;
  endtask

  task automatic modelLookup(input logic [KEY_W-1:0] key, output bit hit, output int idx);
    int best;
    hit = 1'b0; idx = 0; best = -1;
    for (int k = 0; k < ENTRIES; k++) begin
      if (refValid[k] && (((key ^ refAddr[k]) & refMask[k]) == '0)) begin
        if ($countones(refMask[k]) > best) begin
          best = $countones(refMask[k]); idx = k; hit = 1'b1;
        end
      end
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic doOp(input bit del, input int idx, input logic [KEY_W-1:0] addr,
                      input logic [KEY_W-1:0] mask, input string req, output int gotSlot);
    bit expErr; int expSlot;
    if (!del) begin
      expErr = (mCnt == 0);
      expSlot = expErr ? 0 : mStack[mCnt-1];
    end else begin
      expErr = !refValid[idx];
      expSlot = expErr ? 0 : idx;
    end
    opValid = 1'b1; opDelete = del; opIndex = IDX_W'(idx); opAddr = addr; opMask = mask;
    @(negedge clk);
    opValid = 1'b0;
    check(opDone == 1'b1, req, "opDone", 32'(opDone), 32'd1);
    check(opError == expErr, req, "opError", 32'(opError), 32'(expErr));
    check(int'(opSlot) == expSlot, req, "opSlot", 32'(opSlot), 32'(expSlot));
    gotSlot = int'(opSlot);
    if (!expErr) begin
      if (!del) begin
        mCnt--; refValid[expSlot] = 1'b1; refAddr[expSlot] = addr & mask; refMask[expSlot] = mask;
      end else begin
        refValid[idx] = 1'b0; mStack[mCnt] = idx; mCnt++;
      end
    end
  endtask

  task automatic doLookup(input logic [KEY_W-1:0] key, input string req);
    bit eh; int ei;
    modelLookup(key, eh, ei);
    lookupKey = key;
    @(negedge clk);
    check(lookupHit == eh, req, "lookupHit", 32'(lookupHit), 32'(eh));
    check(int'(lookupIndex) == ei, req, "lookupIndex", 32'(lookupIndex), 32'(ei));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    bit eh; int ei;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(lookupHit == 1'b0, "R1", "lookupHit", 32'(lookupHit), 0);
    check(lookupIndex == '0, "R1", "lookupIndex", 32'(lookupIndex), 0);
    check(opDone == 1'b0 && opError == 1'b0, "R1", "op flags", {30'd0, opDone, opError}, 0);
    check(opSlot == '0, "R1", "opSlot", 32'(opSlot), 0);
    doLookup(32'h01020304, "R1");            // empty table misses (R4)

    doOp(1'b1, 0, '0, '0, "R9", s);           // delete on empty table
    doOp(1'b0, 0, 32'h0A000000, lenMask(8),  "R6", s);
    doOp(1'b0, 0, 32'h0A010000, lenMask(16), "R6", s);
    doOp(1'b0, 0, 32'h0A010200, lenMask(24), "R6", s);
    doOp(1'b0, 0, 32'h00000000, lenMask(0),  "R10", s);
    doOp(1'b0, 0, 32'hC0A80000, lenMask(16), "R6", s);
    doOp(1'b0, 0, 32'h0A01FFFF, lenMask(16), "R6", s);
    check(s == 5, "R6", "ascending slot after reset", 32'(s), 32'd5);

    // R2 R3 R10: vector table
    foreach (VECS[v]) begin
      lookupKey = VECS[v][36:5];
      @(negedge clk);
      check(lookupHit == VECS[v][4], "R3", "vector hit", 32'(lookupHit), 32'(VECS[v][4]));
      check(lookupIndex == VECS[v][3:0], (v >= 4) ? "R10" : "R3", "vector index",
            32'(lookupIndex), 32'(VECS[v][3:0]));
    end

    // R5: write and lookup on the same edge, old table first then new
    lookupKey = 32'h0A010203;
    opValid = 1'b1; opDelete = 1'b0; opAddr = 32'h0A010203; opMask = lenMask(32);
    @(negedge clk);
    opValid = 1'b0;
    check(lookupIndex == 4'd2, "R5", "same-edge lookup sees old table", 32'(lookupIndex), 2);
    check(opSlot == 4'd6, "R5", "insert slot", 32'(opSlot), 6);
    mCnt--; refValid[6] = 1'b1; refAddr[6] = 32'h0A010203; refMask[6] = lenMask(32);
    @(negedge clk);
    check(lookupIndex == 4'd6, "R5", "next lookup sees new /32", 32'(lookupIndex), 6);

    // R4 R7: deletes and LIFO reuse
    doOp(1'b1, 3, '0, '0, "R7", s);
    doLookup(32'h08080808, "R4");
    check(lookupHit == 1'b0 && lookupIndex == '0, "R4", "miss after default removed",
          {27'd0, lookupHit, lookupIndex}, 0);
    doOp(1'b1, 1, '0, '0, "R7", s);
    doLookup(32'h0A01FF00, "R7");
    check(lookupIndex == 4'd5, "R7", "remaining equal /16", 32'(lookupIndex), 5);
    doOp(1'b0, 0, 32'hAC100000, lenMask(12), "R7", s);
    check(s == 1, "R7", "reuse most recently freed", 32'(s), 1);
    doOp(1'b1, 3, '0, '0, "R9", s);           // slot 3 already free

    // R8: fill, then a rejected insert changes nothing
    while (mCnt > 0) doOp(1'b0, 0, 32'hAC000000 | ($urandom & 32'h00FFFF00), lenMask(24), "R6", s);
    doOp(1'b0, 0, 32'h0A7F0001, lenMask(32), "R8", s);
    doLookup(32'h0A7F0001, "R8");
    check(lookupIndex == 4'd0, "R8", "rejected /32 not stored", 32'(lookupIndex), 0);

    // Random mix against the model
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 2) begin
        doOp(1'b1, int'($urandom_range(0, ENTRIES-1)), '0, '0, "R7", s);
      end else if (r < 4) begin
        doOp(1'b0, 0, 32'h0A000000 | ($urandom & 32'h0003FFFF),
             lenMask(($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(8, 32))), "R6", s);
      end else begin
        int pick;
        logic [KEY_W-1:0] key;
        pick = int'($urandom_range(0, ENTRIES-1));
        key = refAddr[pick] ^ (32'h1 << $urandom_range(0, 31)) ^ ($urandom & 32'h0000000F);
        if ($urandom_range(0, 3) == 0) key = refAddr[pick];
        doLookup(key, "R3");
      end
    end
    modelLookup(32'h0A000000, eh, ei);
    doLookup(32'h0A000000, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule